// File: doc/BRIEF.md
# Pulse Period and High-Time Capture

This block measures an external digital waveform with one up-counter. A rising edge of the input copies the running count into a period register, restarts the counter and raises a one-cycle capture pulse. A falling edge copies the running count into a staging register. That value moves to the high-time output at the next valid capture, so both outputs always describe the same cycle of the input. Software reads both values on the capture pulse. It derives frequency as counter clock / period and duty cycle as 100 * high / period.

The input is asynchronous and passes through a synchroniser before edge detection. Both edges see the same delay, so the measured durations are exact. The counter advances only on prescaler ticks, which stretches the measurable range. A period that does not fit in the counter is reported through an overflow flag and produces no capture.

Top module: `pwm_capture`

## Requirements
- R1: While rst_ni is low, period_o, high_o, valid_o and ovf_o are all zero.
- R2: sig_i passes through a two-flop synchroniser and one edge-detect register. valid_o is high in the third clock cycle after the first clock edge that samples the new high level of sig_i.
- R3: On a valid capture, period_o equals 1 + floor((P-1)/(N+1)), where P is the input period in clock cycles and N is psc_i. With N = 0 this is P.
- R4: On a valid capture, high_o equals 1 + floor((H-1)/(N+1)), where H is the high time of the same input period in clock cycles.
- R5: valid_o is a single-cycle pulse, issued once for each measured period. period_o and high_o change only in a cycle where valid_o is high.
- R6: The first rising edge after en_i goes high only restarts the counter. It produces no capture.
- R7: While en_i is low, no capture occurs, ovf_o is cleared, period_o and high_o hold their values, and the next enable starts unarmed.
- R8: The counter saturates at 2^CNT_W-1. A prescaler tick at that value during an armed period sets ovf_o. The rising edge that ends such a period produces no capture and leaves period_o unchanged.
- R9: Once set, ovf_o stays high until the next valid capture. ovf_o is low in every cycle where valid_o is high.
- R10: The prescaler divides the clock by psc_i+1 and restarts at every rising edge of the synchronised input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Measurement enable |
| psc_i | input | PSC_W | Prescaler value N; the counter advances every N+1 clocks |
| sig_i | input | 1 | Asynchronous signal to measure |
| period_o | output | CNT_W | Captured period in counter ticks |
| high_o | output | CNT_W | Captured high time in counter ticks |
| valid_o | output | 1 | One-cycle pulse when a new capture is presented |
| ovf_o | output | 1 | Counter overflowed in a measured period |

## Verification
Four properties are checked on every cycle:
- valid_o lasts a single cycle.
- Both capture outputs hold still between captures.
- A capture never coincides with ovf_o and never reports a zero period.
- Disabling the block suppresses captures and the overflow flag.

The exact captured values, the synchroniser latency and the prescaled tick counts can only be shown by the bench's scenarios. The same holds for the unarmed first edge and for the saturation boundary, where one extra clock separates a full-scale capture from an overflow.

// File: rtl/pwmcap_pkg.sv
package pwmcap_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/pwmcap_sync.sv
module pwmcap_sync
  import pwmcap_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sig_i,
  output edge_t edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], sig_i};
      prev_q <= lvl;
    end
  end

  assign edge_o.rise = lvl & ~prev_q;
  assign edge_o.fall = ~lvl & prev_q;
endmodule

// File: rtl/pwmcap_prescale.sv
module pwmcap_prescale #(
  parameter int PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] div_q;

  // >= keeps a lowered psc_i from forcing a full wrap
  assign tick_o = en_i && (div_q >= psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            div_q <= '0;
    else if (!en_i || restart_i || tick_o)  div_q <= '0;
    else                                    div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pwmcap_counter.sv
module pwmcap_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);
  assign wrap_o = en_i && !restart_i && tick_i && at_max;
  assign cnt_o  = cnt_q;

  // restart to one so a period of P ticks reads back as P
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= CNT_ONE;
    else if (!en_i || restart_i)     cnt_q <= CNT_ONE;
    else if (tick_i && !at_max)      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwmcap_capture.sv
module pwmcap_capture
  import pwmcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  edge_t            edge_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wrap_i,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] high_o,
  output logic             valid_o,
  output logic             ovf_o
);
  logic             armed_q;
  logic             bad_q;
  logic [CNT_W-1:0] high_stage_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] high_q;
  logic             valid_q;
  logic             ovf_q;
  logic             good;

  assign good = armed_q && !bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q      <= 1'b0;
      bad_q        <= 1'b0;
      high_stage_q <= '0;
      period_q     <= '0;
      high_q       <= '0;
      valid_q      <= 1'b0;
      ovf_q        <= 1'b0;
    end else if (!en_i) begin
      armed_q <= 1'b0;
      bad_q   <= 1'b0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (edge_i.rise) begin
        armed_q <= 1'b1;
        bad_q   <= 1'b0;
        if (good) begin
          period_q <= cnt_i;
          high_q   <= high_stage_q;
          valid_q  <= 1'b1;
          ovf_q    <= 1'b0;
        end
      end else begin
        if (edge_i.fall && good) high_stage_q <= cnt_i;
        if (wrap_i && armed_q) begin
          bad_q <= 1'b1;
          ovf_q <= 1'b1;
        end
      end
    end
  end

  assign period_o = period_q;
  assign high_o   = high_q;
  assign valid_o  = valid_q;
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/pwm_capture.sv
module pwm_capture
  import pwmcap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PSC_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             sig_i,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] high_o,
  output logic             valid_o,
  output logic             ovf_o
);
  edge_t            edges;
  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] cnt;

  pwmcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sig_i),
    .edge_o (edges)
  );

  pwmcap_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .restart_i (edges.rise),
    .psc_i     (psc_i),
    .tick_o    (tick)
  );

  pwmcap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .restart_i (edges.rise),
    .tick_i    (tick),
    .cnt_o     (cnt),
    .wrap_o    (wrap)
  );

  pwmcap_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .edge_i   (edges),
    .cnt_i    (cnt),
    .wrap_i   (wrap),
    .period_o (period_o),
    .high_o   (high_o),
    .valid_o  (valid_o),
    .ovf_o    (ovf_o)
  );
endmodule

// File: rtl/pwm_capture_chk.sv
module pwm_capture_chk #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [PSC_W-1:0] psc_i,
  input logic             sig_i,
  input logic [CNT_W-1:0] period_o,
  input logic [CNT_W-1:0] high_o,
  input logic             valid_o,
  input logic             ovf_o
);
  assert_valid_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_hold_between_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(period_o) && $stable(high_o)));

  assert_period_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (period_o != '0));

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !ovf_o);

  assert_disabled_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (!valid_o && !ovf_o));
endmodule

bind pwm_capture pwm_capture_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (.*);

// File: tb/pwm_capture_test.sv
module pwm_capture_test;
  localparam int CNT_W = 10;
  localparam int PSC_W = 4;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic             sig = 1'b0;
  logic [PSC_W-1:0] psc = '0;
  logic [CNT_W-1:0] period_o, high_o;
  logic             valid_o, ovf_o;

  always #2 clk = ~clk;

  pwm_capture #(.CNT_W(CNT_W), .PSC_W(PSC_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .psc_i(psc), .sig_i(sig),
    .period_o(period_o), .high_o(high_o), .valid_o(valid_o), .ovf_o(ovf_o)
  );

  int n_checks = 0, n_errors = 0, cyc = 0, n_valid = 0;
  int q_per[$], q_high[$], q_cyc[$];
  bit m_armed = 0;
  int m_h = 0, m_p = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_count(int n, int p);
    return 1 + (n - 1) / (p + 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  // One input period: high for h clocks then low for l; caller sits on a negedge
  task automatic run_period(input int h, input int l);
    sig = 1'b1;
    if (m_armed) begin
      if ((m_p - 1) / (int'(psc) + 1) < MAXC) begin
        q_per.push_back(exp_count(m_p, int'(psc)));
        q_high.push_back(exp_count(m_h, int'(psc)));
        q_cyc.push_back(cyc + 3);
      end
    end
    m_armed = 1;
    m_h = h;
    m_p = h + l;
    repeat (h) @(negedge clk);
    sig = 1'b0;
    repeat (l) @(negedge clk);
  endtask

  task automatic disable_blk();
    repeat (5) @(negedge clk);
    en = 1'b0;
    m_armed = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic enable_blk(input int p);
    psc = PSC_W'(p);
    en = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      n_valid++;
      if (q_per.size() == 0) begin
        check(0, "R6 unexpected capture", 1, 0);
      end else begin
        int ep, eh, ec;
        ep = q_per.pop_front();
        eh = q_high.pop_front();
        ec = q_cyc.pop_front();
        check(int'(period_o) == ep, "R3 period", int'(period_o), ep);
        check(int'(high_o) == eh, "R4 high", int'(high_o), eh);
        check(cyc == ec, "R2 latency", cyc, ec);
        check(!ovf_o, "R9 ovf at capture", int'(ovf_o), 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL R5 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed_v;
    int nv0;
    logic [CNT_W-1:0] snap_p, snap_h;
    seed_v = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check(period_o == '0 && high_o == '0, "R1 captures", int'(period_o) + int'(high_o), 0);
    check(!valid_o && !ovf_o, "R1 flags", int'(valid_o) + int'(ovf_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    enable_blk(0);

    // R6: first rise only arms
    nv0 = n_valid;
    run_period(5, 5);
    check(n_valid == nv0, "R6 first edge", n_valid - nv0, 0);

    run_period(3, 7);
    run_period(1, 1);
    run_period(10, 20);
    run_period(1, 9);
    for (int i = 0; i < 60; i++) run_period(1 + $urandom % 40, 1 + $urandom % 40);

    // R10: prescaled runs
    for (int r = 0; r < 4; r++) begin
      disable_blk();
      enable_blk(1 + $urandom % 3);
      for (int i = 0; i < 25; i++) run_period(1 + $urandom % 30, 1 + $urandom % 30);
    end

    // R8 boundary at psc 0: full scale valid, one more clock overflows
    disable_blk();
    enable_blk(0);
    run_period(2, 2);
    run_period(1, 1022);
    run_period(1, 1023);
    run_period(4, 4);
    check(ovf_o, "R8 overflow flag", int'(ovf_o), 1);
    snap_p = period_o;
    check(int'(snap_p) == MAXC, "R8 no capture after overflow", int'(snap_p), MAXC);
    run_period(4, 4);
    repeat (4) @(negedge clk);
    check(!ovf_o, "R9 cleared by capture", int'(ovf_o), 0);

    // R8 boundary with psc 1
    disable_blk();
    enable_blk(1);
    run_period(2, 2);
    run_period(1, 2045);
    run_period(1, 2046);
    run_period(3, 3);
    check(ovf_o, "R8 overflow flag psc1", int'(ovf_o), 1);
    run_period(3, 3);
    run_period(2, 2);
    repeat (4) @(negedge clk);

    // R7: disabled block ignores the input
    disable_blk();
    snap_p = period_o;
    snap_h = high_o;
    nv0 = n_valid;
    for (int i = 0; i < 5; i++) begin
      sig = 1'b1;
      repeat (3 + i) @(negedge clk);
      sig = 1'b0;
      repeat (4) @(negedge clk);
    end
    check(n_valid == nv0, "R7 no capture", n_valid - nv0, 0);
    check(period_o == snap_p, "R7 period held", int'(period_o), int'(snap_p));
    check(high_o == snap_h, "R7 high held", int'(high_o), int'(snap_h));
    check(!ovf_o, "R7 ovf cleared", int'(ovf_o), 0);

    enable_blk(0);
    nv0 = n_valid;
    run_period(6, 6);
    check(n_valid == nv0, "R7 R6 unarmed after enable", n_valid - nv0, 0);
    run_period(7, 9);
    run_period(2, 3);
    repeat (6) @(negedge clk);
    check(q_per.size() == 0, "R5 all captures seen", q_per.size(), 0);
    finish_run();
  end
endmodule